// File: doc/BRIEF.md
# Multicast Hash Table Filter

This block decides whether a received multicast destination address passes a hashed filter. Two bytes of the destination address (byte 4 and byte 5, counted from the first byte on the wire) are folded into a 12-bit hash. The hash selects one bit of a 4096-bit table, and that bit is the verdict. A 2-bit filter-type input slides the hash window across the two bytes. The total shift between the two bytes is always 8 bits, so the window stays 8 bits wide in the two-byte field.

The table is held as 128 words of 32 bits. Software replaces the contents through a simple word-wide register port, with one write strobe and one combinational read path at the same address. A complete reprogramming zeroes every word and then sets one bit for each wanted address. The receive path strobes a lookup with the two address bytes and the filter type. It gets back a registered verdict, together with the hash it used, one cycle later. The unicast or multicast decision and the dropping of frames are left to surrounding logic.

Top module: `mc_hash_filter`

## Requirements
- R1: The hash is `((b4 >> (8 - s)) | (b5 << s))` keeping the low 12 bits, with s = 4 + e. The extra shift e is 0 for filter type 0, 1 for type 1, 2 for type 2 and 4 for type 3. For b4=0x34, b5=0x56 the hashes of types 0..3 are 0x563, 0xAC6, 0x58D and 0x634.
- R2: The verdict `acc_hit` equals bit hash[4:0] of table word hash[11:5].
- R3: `acc_valid`, `acc_hit` and `acc_hash` are registered, and the cycle after a cycle with `lk_valid` high they show that lookup. The cycle after a cycle with `lk_valid` low, both `acc_valid` and `acc_hit` are 0.
- R4: When `reg_wr` is high at a clock edge, the whole word at `reg_addr` is replaced by `reg_wdata`. `reg_rdata` always shows the current word at `reg_addr`.
- R5: A lookup strobed in the same cycle as a table write sees the contents from before the write. Lookups strobed afterwards see the new contents.
- R6: Reset clears every table word to zero and drives `acc_valid` and `acc_hit` low, so no address is accepted until software programs the table.
- R7: Lookups never change table contents. After a full reprogramming (all words zeroed, then one bit set per listed address), exactly the listed addresses' hash positions hit.
- R8: Bit 31 of word 127 (hash 0xFFF) and bit 0 of word 0 (hash 0x000) are reachable, and setting one bit does not make its neighbours hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Table word write strobe |
| reg_addr | input | 7 | Table word index for write and read |
| reg_wdata | input | 32 | Table word write data |
| reg_rdata | output | 32 | Table word at `reg_addr` (combinational) |
| lk_valid | input | 1 | Lookup strobe |
| lk_b4 | input | 8 | Destination address byte 4 |
| lk_b5 | input | 8 | Destination address byte 5 |
| lk_ftype | input | 2 | Filter type selecting the hash window |
| acc_valid | output | 1 | Lookup result valid |
| acc_hit | output | 1 | Address accepted by the table |
| acc_hash | output | 12 | Hash used by the reported lookup |

## Verification
A lookup result is due exactly one clock edge after its strobe. The bench drives every strobe on a falling edge, lets one rising edge pass, and samples `acc_valid`, `acc_hit` and `acc_hash` on the following falling edge, before it removes the strobe. Register writes take effect at the same edge. Read data is combinational, so readbacks are sampled on the falling edge after the write edge. The same-cycle write and lookup case is checked on the first falling edge after the shared edge, where the old table bit must appear, and then again with a fresh lookup one cycle later.

// File: rtl/mc_hash_filter.sv
module mc_hash_filter #(
  parameter  int TBL_WORDS  = 128,
  parameter  int WORD_W     = 32,
  localparam int IDX_W      = $clog2(TBL_WORDS),
  localparam int BIT_W      = $clog2(WORD_W),
  localparam int HASH_W     = IDX_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              lk_valid,
  input  logic [7:0]        lk_b4,
  input  logic [7:0]        lk_b5,
  input  logic [1:0]        lk_ftype,
  output logic              acc_valid,
  output logic              acc_hit,
  output logic [HASH_W-1:0] acc_hash
);
  localparam int BASE_SHIFT = HASH_W - 8;

  logic [WORD_W-1:0] tbl [TBL_WORDS];
  logic [3:0]        extra;
  logic [3:0]        sh;
  logic [15:0]       mix;
  logic [HASH_W-1:0] hash;
  logic [IDX_W-1:0]  h_idx;
  logic [BIT_W-1:0]  h_bit;

  always_comb begin
    case (lk_ftype)
      2'd1:    extra = 4'd1;
      2'd2:    extra = 4'd2;
      2'd3:    extra = 4'd4;
      default: extra = 4'd0;
    endcase
  end

  assign sh    = 4'(BASE_SHIFT) + extra;
  assign mix   = ({8'h00, lk_b4} >> (4'd8 - sh)) | ({8'h00, lk_b5} << sh);
  assign hash  = mix[HASH_W-1:0];
  assign h_idx = hash[HASH_W-1:BIT_W];
  assign h_bit = hash[BIT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_WORDS; i++) tbl[i] <= '0;
    end else if (reg_wr) begin
      tbl[reg_addr] <= reg_wdata;
    end
  end

  assign reg_rdata = tbl[reg_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_hit   <= 1'b0;
      acc_hash  <= '0;
    end else begin
      acc_valid <= lk_valid;
      acc_hit   <= lk_valid & tbl[h_idx][h_bit];
      if (lk_valid) acc_hash <= hash;
    end
  end

  // R3
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> acc_valid);

  // R3
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!acc_valid && !acc_hit));

  // R3
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> acc_valid);

  // R4
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !lk_valid) ##1 $stable(reg_addr) |-> reg_rdata == $past(reg_wdata));

  // R1
  widest_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ftype == 2'd3 && BASE_SHIFT == 4) |=>
      acc_hash == HASH_W'({$past(lk_b5), $past(lk_b4)}));

  // R7
  lookup_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && lk_valid) ##1 $stable(reg_addr) |-> $stable(reg_rdata));
endmodule

// File: tb/mc_hash_filter_tb.sv
`timescale 1ns/1ps
module mc_hash_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_b4 = '0, lk_b5 = '0;
  logic [1:0]  lk_ftype = '0;
  logic        acc_valid, acc_hit;
  logic [11:0] acc_hash;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow [128];

  always #2.5 clk = ~clk;

  mc_hash_filter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_b4(lk_b4), .lk_b5(lk_b5), .lk_ftype(lk_ftype),
    .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_hash(acc_hash));

  function automatic logic [11:0] model_hash(logic [7:0] b4, logic [7:0] b5, logic [1:0] ft);
    int s;
    logic [15:0] v;
    s = 4 + ((ft == 2'd3) ? 4 : int'(ft));
    v = ({8'h00, b4} >> (8 - s)) | ({8'h00, b5} << s);
    return v[11:0];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_word(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    shadow[a] = d;
  endtask

  task automatic lookup(string req, logic [7:0] b4, logic [7:0] b5, logic [1:0] ft,
                        logic exp_hit, logic [11:0] exp_hash);
    @(negedge clk);
    lk_valid = 1'b1; lk_b4 = b4; lk_b5 = b5; lk_ftype = ft;
    @(negedge clk);
    check(req, "acc_valid", 32'(acc_valid), 32'd1);
    check(req, "acc_hash", 32'(acc_hash), 32'(exp_hash));
    check(req, "acc_hit", 32'(acc_hit), 32'(exp_hit));
    lk_valid = 1'b0;
  endtask

  function automatic logic exp_bit(logic [11:0] h);
    return shadow[h[11:5]][h[4:0]];
  endfunction

  task automatic t_reset;
    for (int i = 0; i < 128; i++) shadow[i] = '0;
    @(negedge clk);
    check("R6", "acc_valid after reset", 32'(acc_valid), 32'd0);
    check("R6", "acc_hit after reset", 32'(acc_hit), 32'd0);
    for (int i = 0; i < 128; i += 9) begin
      reg_addr = 7'(i);
      #0.1;
      check("R6", "table word zero after reset", reg_rdata, 32'd0);
    end
    reg_addr = 7'd127; #0.1;
    check("R6", "last word zero after reset", reg_rdata, 32'd0);
    lookup("R6", 8'h34, 8'h56, 2'd0, 1'b0, 12'h563);
  endtask

  task automatic t_hash_types;
    lookup("R1", 8'h34, 8'h56, 2'd0, 1'b0, 12'h563);
    lookup("R1", 8'h34, 8'h56, 2'd1, 1'b0, 12'hAC6);
    lookup("R1", 8'h34, 8'h56, 2'd2, 1'b0, 12'h58D);
    lookup("R1", 8'h34, 8'h56, 2'd3, 1'b0, 12'h634);
    lookup("R1", 8'hA5, 8'hC3, 2'd2, 1'b0, model_hash(8'hA5, 8'hC3, 2'd2));
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R3", "acc_valid low without strobe", 32'(acc_valid), 32'd0);
    check("R3", "acc_hit low without strobe", 32'(acc_hit), 32'd0);
  endtask

  task automatic t_hit;
    wr_word(7'h2B, 32'h0000_0008);
    lookup("R2", 8'h34, 8'h56, 2'd0, 1'b1, 12'h563);
    lookup("R2", 8'h34, 8'h56, 2'd1, 1'b0, 12'hAC6);
    reg_addr = 7'h2B; #0.1;
    check("R4", "readback word 0x2B", reg_rdata, 32'h0000_0008);
    wr_word(7'h2B, 32'h0000_0010);
    reg_addr = 7'h2B; #0.1;
    check("R4", "word replaced", reg_rdata, 32'h0000_0010);
    lookup("R4", 8'h34, 8'h56, 2'd0, 1'b0, 12'h563);
  endtask

  task automatic t_edges;
    wr_word(7'd127, 32'h8000_0000);
    lookup("R8", 8'hFF, 8'h0F, 2'd3, 1'b1, 12'hFFF);
    lookup("R8", 8'hF0, 8'hFF, 2'd0, 1'b1, 12'hFFF);
    lookup("R8", 8'hFE, 8'h0F, 2'd3, 1'b0, 12'hFFE);
    wr_word(7'd0, 32'h0000_0001);
    lookup("R8", 8'h00, 8'h00, 2'd1, 1'b1, 12'h000);
    lookup("R8", 8'h01, 8'h00, 2'd3, 1'b0, 12'h001);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'h56; reg_wdata = 32'h0000_0040;
    lk_valid = 1'b1; lk_b4 = 8'h34; lk_b5 = 8'h56; lk_ftype = 2'd1;
    @(negedge clk);
    check("R5", "same-cycle lookup sees old bit", 32'(acc_hit), 32'd0);
    check("R5", "same-cycle lookup valid", 32'(acc_valid), 32'd1);
    reg_wr = 1'b0;
    shadow[7'h56] = 32'h0000_0040;
    lk_valid = 1'b0;
    lookup("R5", 8'h34, 8'h56, 2'd1, 1'b1, 12'hAC6);
  endtask

  task automatic t_full_update;
    logic [7:0] lb4 [3] = '{8'h12, 8'h9C, 8'h00};
    logic [7:0] lb5 [3] = '{8'h34, 8'h7E, 8'hFF};
    logic [31:0] img [128];
    for (int i = 0; i < 128; i++) img[i] = '0;
    for (int k = 0; k < 3; k++) begin
      logic [11:0] h;
      h = model_hash(lb4[k], lb5[k], 2'd2);
      img[h[11:5]][h[4:0]] = 1'b1;
    end
    for (int i = 0; i < 128; i++) wr_word(7'(i), img[i]);
    for (int k = 0; k < 3; k++)
      lookup("R7", lb4[k], lb5[k], 2'd2, 1'b1, model_hash(lb4[k], lb5[k], 2'd2));
    lookup("R7", 8'h34, 8'h56, 2'd0, exp_bit(12'h563), 12'h563);
    lookup("R7", 8'h55, 8'h21, 2'd2, exp_bit(model_hash(8'h55, 8'h21, 2'd2)),
           model_hash(8'h55, 8'h21, 2'd2));
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      reg_addr = 7'(i);
      #0.1;
      check("R7", "table unchanged by lookups", reg_rdata, shadow[i]);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hash_types();
    t_idle();
    t_hit();
    t_edges();
    t_same_cycle();
    t_idle();
    t_full_update();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule